// File: doc/BRIEF.md
# Three-Wire Serial Control Register Bank

This block is a write-only configuration port for a transmitter synthesizer. A host drives three wires: an active-low select, a serial clock and a data line. While select is low, each rising serial-clock edge shifts one bit into a 20-bit frame register, most significant bit first. The frame carries a 16-bit value in its upper bits and a 4-bit register address in its lowest four bits. When select returns high, the value is written into the register that the address names.

Three registers are held: a reference-divider word, a main-divider word and an operating-control word. Each has its own nonzero default value. All three are presented continuously as parallel outputs. The bus may be shared with other devices, so a frame whose address matches none of the three registers is discarded without effect. The three serial wires are brought into the system clock domain through a synchronizer, and all register updates happen on the system clock.

Top module: `txcfg_serial_bank`

## Requirements
- R1: After reset the reference-divider output reads 0x4050, the main-divider output reads 0x2616 (decimal 9750) and the control output reads 0x197D.
- R2: A frame is taken MSB first; in a 20-bit frame, bits 19..4 are the value and bits 3..0 are the address.
- R3: A frame with address 0x0 writes its value to the reference-divider output.
- R4: A frame with address 0x2 writes its value to the main-divider output.
- R5: A frame with address 0x4 writes its value to the control output.
- R6: A frame with any other address changes none of the three outputs.
- R7: Serial-clock edges while select is high shift nothing into the frame register.
- R8: On the rising edge of select, the last 20 bits shifted in are used, whether more or fewer than 20 bits were sent in that select-low window (bits from earlier frames fill the remainder).
- R9: A written value appears on the output at the third system-clock rising edge after select rises, and the outputs change at no other time.
- R10: A serial-clock rising edge that reaches the system domain in the same cycle as the select rising edge is shifted in and included in the written frame.
- R11: Synchronous active-low reset returns all three outputs to their defaults and clears the frame register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_sel_n | input | 1 | Serial select, low while a frame is sent |
| cfg_sck | input | 1 | Serial clock, data taken on its rising edge |
| cfg_sdi | input | 1 | Serial data, MSB first |
| refdiv_o | output | 16 | Reference-divider register contents |
| maindiv_o | output | 16 | Main-divider register contents |
| ctrl_o | output | 16 | Operating-control register contents |

## Verification
The last bit shift and the register commit can land in the same system cycle when the serial clock and select rise together. The bench provokes this by sending nineteen bits normally and raising the twentieth clock edge and select at the same instant, then judges that the written value contains that final bit rather than the frame register's stale content. Separately, the commit latency is judged by sampling the target output one cycle before and exactly at the third edge after select rises.

// File: rtl/txcfg_pkg.sv
// Shared widths, addresses and reset values of the serial register bank.
package txcfg_pkg;
    localparam int DATA_W   = 16;
    localparam int ADDR_W   = 4;
    localparam int FRAME_W  = DATA_W + ADDR_W;
    localparam int NUM_REGS = 3;

    typedef logic [DATA_W-1:0] word_t;
    typedef logic [ADDR_W-1:0] addr_t;

    // Index 0: reference divider, 1: main divider, 2: operating control.
    localparam addr_t REG_ADDR [NUM_REGS] = '{4'h0, 4'h2, 4'h4};
    localparam word_t REG_DEF  [NUM_REGS] = '{16'h4050, 16'd9750, 16'h197D};
endpackage

// File: rtl/txcfg_sync.sv
// Multi-stage synchronizer for a bundle of slow asynchronous inputs.
// Assumes each input is held for several system clocks; also outputs the
// value one cycle older so the caller can detect edges.
module txcfg_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] cur_o,
    output logic [WIDTH-1:0] prev_o
);
    logic [WIDTH-1:0] stage_q [STAGES];
    logic [WIDTH-1:0] prev_q;

    // Shift the inputs through the synchronizer chain and keep one extra copy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stage_q[i] <= RST_VAL;
            prev_q <= RST_VAL;
        end else begin
            stage_q[0] <= async_i;
            for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
            prev_q <= stage_q[STAGES-1];
        end
    end

    assign cur_o  = stage_q[STAGES-1];
    assign prev_o = prev_q;
endmodule

// File: rtl/txcfg_shifter.sv
// Frame shift register. Assumes shift_en is a single-cycle strobe per
// serial bit. Exposes the next-state value so a commit in the same cycle
// as a shift sees the newly shifted bit.
module txcfg_shifter
    import txcfg_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               shift_en,
    input  logic               bit_i,
    output logic [FRAME_W-1:0] frame_nxt_o
);
    logic [FRAME_W-1:0] frame_q;

    // Next frame value: shifted when a bit arrives, held otherwise.
    always_comb begin
        frame_nxt_o = shift_en ? {frame_q[FRAME_W-2:0], bit_i} : frame_q;
    end

    // Register the frame.
    always_ff @(posedge clk) begin
        if (!rst_n) frame_q <= '0;
        else        frame_q <= frame_nxt_o;
    end

    // R7
    no_shift_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_en |=> $stable(frame_q));
endmodule

// File: rtl/txcfg_regbank.sv
// Addressed register bank. On a commit strobe, writes the frame's value
// field into the register whose address equals the frame's low bits;
// frames with no matching address are dropped.
module txcfg_regbank
    import txcfg_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               commit,
    input  logic [FRAME_W-1:0] frame_i,
    output word_t              regs_o [NUM_REGS]
);
    addr_t frame_addr;
    word_t frame_data;
    logic  any_hit;

    assign frame_addr = frame_i[ADDR_W-1:0];
    assign frame_data = frame_i[FRAME_W-1:ADDR_W];

    // Flag whether the frame address belongs to this bank.
    always_comb begin
        any_hit = 1'b0;
        for (int i = 0; i < NUM_REGS; i++)
            if (frame_addr == REG_ADDR[i]) any_hit = 1'b1;
    end

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        // Hold one register, load on a matching commit.
        always_ff @(posedge clk) begin
            if (!rst_n)
                regs_o[g] <= REG_DEF[g];
            else if (commit && frame_addr == REG_ADDR[g])
                regs_o[g] <= frame_data;
        end

        // R11
        reset_default_chk: assert property (@(posedge clk)
            !rst_n |=> regs_o[g] == REG_DEF[g]);

        // R9
        quiet_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !commit |=> $stable(regs_o[g]));

        // R6
        unused_addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (commit && !any_hit) |=> $stable(regs_o[g]));

        // R3
        write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (commit && frame_addr == REG_ADDR[g]) |=> regs_o[g] == $past(frame_data));
    end
endmodule

// File: rtl/txcfg_serial_bank.sv
// Top of the three-wire serial register bank. Synchronizes select, clock
// and data into clk, shifts a bit on each serial-clock rise seen while
// select was low, and commits the frame when select rises. Assumes the
// serial clock is several times slower than clk.
module txcfg_serial_bank
    import txcfg_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_sel_n,
    input  logic        cfg_sck,
    input  logic        cfg_sdi,
    output logic [15:0] refdiv_o,
    output logic [15:0] maindiv_o,
    output logic [15:0] ctrl_o
);
    localparam int IDX_SCK = 0;
    localparam int IDX_SDI = 1;
    localparam int IDX_SEL = 2;

    logic [2:0]         sync_cur, sync_prev;
    logic               sck_rise, sel_rise, shift_en;
    logic [FRAME_W-1:0] frame_nxt;
    word_t              regs [NUM_REGS];

    txcfg_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) sync_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .async_i({cfg_sel_n, cfg_sdi, cfg_sck}),
        .cur_o  (sync_cur),
        .prev_o (sync_prev)
    );

    // Edge strobes; a shift counts if select was still low one cycle earlier.
    always_comb begin
        sck_rise = sync_cur[IDX_SCK] & ~sync_prev[IDX_SCK];
        sel_rise = sync_cur[IDX_SEL] & ~sync_prev[IDX_SEL];
        shift_en = sck_rise & ~sync_prev[IDX_SEL];
    end

    txcfg_shifter shift_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .shift_en   (shift_en),
        .bit_i      (sync_cur[IDX_SDI]),
        .frame_nxt_o(frame_nxt)
    );

    txcfg_regbank bank_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .commit (sel_rise),
        .frame_i(frame_nxt),
        .regs_o (regs)
    );

    assign refdiv_o  = regs[0];
    assign maindiv_o = regs[1];
    assign ctrl_o    = regs[2];

    // R10
    joint_shift_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_rise && shift_en && frame_nxt[ADDR_W-1:0] == REG_ADDR[0])
        |=> refdiv_o == $past(frame_nxt[FRAME_W-1:ADDR_W]));
endmodule

// File: tb/txcfg_serial_bank_tb_top.sv
module txcfg_serial_bank_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_sel_n = 1'b1;
    logic cfg_sck = 1'b0;
    logic cfg_sdi = 1'b0;
    logic [15:0] refdiv_o, maindiv_o, ctrl_o;

    always #2 clk = ~clk;

    txcfg_serial_bank dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_sel_n(cfg_sel_n), .cfg_sck(cfg_sck),
        .cfg_sdi(cfg_sdi), .refdiv_o(refdiv_o), .maindiv_o(maindiv_o), .ctrl_o(ctrl_o)
    );

    typedef struct {
        logic [15:0] r, m, c;
        string       tag;
    } exp_t;

    exp_t        q[$];
    exp_t        it;
    int          n_vec = 0;
    int          n_bad = 0;
    bit          done = 0;
    logic [15:0] sh_ref, sh_main, sh_ctrl;
    logic [19:0] sh_frame;

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic model_reset();
        sh_ref = 16'h4050; sh_main = 16'd9750; sh_ctrl = 16'h197D; sh_frame = '0;
    endtask

    task automatic model_commit();
        case (sh_frame[3:0])
            4'h0: sh_ref  = sh_frame[19:4];
            4'h2: sh_main = sh_frame[19:4];
            4'h4: sh_ctrl = sh_frame[19:4];
            default: ;
        endcase
    endtask

    task automatic push_exp(input string tag);
        wait_clk(8);
        q.push_back('{sh_ref, sh_main, sh_ctrl, tag});
        wait_clk(2);
    endtask

    task automatic shift_bit(input logic b);
        cfg_sdi = b; wait_clk(4);
        cfg_sck = 1'b1; sh_frame = {sh_frame[18:0], b}; wait_clk(4);
        cfg_sck = 1'b0;
    endtask

    // Send n bits MSB first inside one select-low window.
    task automatic send(input logic [31:0] bits, input int n, input string tag);
        @(negedge clk); cfg_sel_n = 1'b0; wait_clk(4);
        for (int i = n - 1; i >= 0; i--) shift_bit(bits[i]);
        wait_clk(4); cfg_sel_n = 1'b1;
        model_commit();
        push_exp(tag);
    endtask

    task automatic check(input logic [15:0] act, input logic [15:0] exp, input string tag);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Monitor: compare outputs against each expected item as it arrives.
    always @(negedge clk) begin
        if (q.size() > 0) begin
            it = q.pop_front();
            n_vec++;
            if (refdiv_o !== it.r || maindiv_o !== it.m || ctrl_o !== it.c) begin
                n_bad++;
                $display("FAIL %s actual=%h/%h/%h expected=%h/%h/%h", it.tag,
                         refdiv_o, maindiv_o, ctrl_o, it.r, it.m, it.c);
            end
        end
    end

    initial begin
        #400000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        model_reset();
        wait_clk(4);
        rst_n = 1'b1;
        wait_clk(2);
        push_exp("R1 defaults");

        send({16'hA5C3, 4'h0}, 20, "R2 R3 ref write");
        send({16'h3C5A, 4'h2}, 20, "R4 main write");
        send({16'hF00F, 4'h4}, 20, "R5 ctrl write");
        send({16'h1111, 4'h1}, 20, "R6 addr 1 dropped");
        send({16'h2222, 4'hF}, 20, "R6 addr F dropped");
        send({16'h3333, 4'h8}, 20, "R6 addr 8 dropped");

        // R7: stray clocks while select is high, then an empty frame.
        send({16'h7777, 4'h0}, 20, "R3 ref write");
        for (int i = 3; i >= 0; i--) begin
            cfg_sdi = (i == 1); wait_clk(4); cfg_sck = 1'b1; wait_clk(4); cfg_sck = 1'b0;
        end
        send(32'h0, 0, "R7 clocks ignored while deselected");

        send({4'hE, 16'h5A5A, 4'h4}, 24, "R8 long frame last 20 bits");
        send(32'h0000_00C2, 8, "R8 short frame mixes old bits");

        // R10: last clock edge and select rise at the same instant.
        @(negedge clk); cfg_sel_n = 1'b0; wait_clk(4);
        for (int i = 19; i >= 1; i--) shift_bit(logic'((20'h6E590 >> i) & 1));
        cfg_sdi = 1'b0; wait_clk(4);
        cfg_sck = 1'b1; cfg_sel_n = 1'b1; sh_frame = {sh_frame[18:0], 1'b0};
        model_commit();
        wait_clk(4); cfg_sck = 1'b0;
        push_exp("R10 joint shift and commit");

        // R9: latency of exactly three system edges after select rises.
        @(negedge clk); cfg_sel_n = 1'b0; wait_clk(4);
        for (int i = 19; i >= 0; i--) shift_bit(logic'((20'hBEEF0 >> i) & 1));
        wait_clk(4);
        cfg_sel_n = 1'b1;
        @(posedge clk); @(posedge clk); @(negedge clk);
        check(refdiv_o, sh_ref, "R9 not yet updated at edge 2");
        @(posedge clk); @(negedge clk);
        check(refdiv_o, 16'hBEEF, "R9 updated at edge 3");
        model_commit();
        push_exp("R9 settled");

        // R11: synchronous reset mid-run.
        @(negedge clk); rst_n = 1'b0; wait_clk(3); rst_n = 1'b1;
        model_reset();
        push_exp("R11 reset restores defaults");
        send(32'h0, 0, "R11 frame register cleared");

        wait_clk(10);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule